// File: doc/BRIEF.md
# Self-Routing Multistage Cube Switch Network

This block is a packet switch with N inputs and N outputs. It is built from 2x2 switch elements arranged in log2(N) stages. Every input accepts a packet through a valid/ready handshake. A packet carries a destination port number and a payload. A perfect-shuffle wiring pattern joins each stage to the next.

Each element looks at one bit of a packet's destination and forwards the packet to its upper or lower exit. The first stage uses the most significant bit. Delivery therefore depends only on the destination and never on the source port. Each source and destination pair has exactly one path, so there is no route around a busy element.

Each element holds a one-entry register on each exit. When both inputs of an element want the same exit in the same cycle, a round-robin pointer in that element chooses the winner. The losing packet keeps its request asserted. When an output is blocked, the stall spreads back along the shared path and holds up every packet that needs one of the full registers.

Top module: `cube_route_net`

## Requirements
- R1: After reset, every `outValid` bit is 0, and `inReady` stays 0 on every input whose `inValid` is 0.
- R2: A packet accepted on any input with destination d is presented exactly once on output d, with its payload unchanged.
- R3: In an empty network with all outputs ready, a packet leaves on the LOG2N-th rising clock edge after the edge that accepted it (4 edges with the default parameters).
- R4: Stage k steers on destination bit LOG2N-1-k: 0 takes the upper (even) exit and 1 takes the lower (odd) exit. As a result, inputs s and s+N/2 meet in the same first-stage element. When both target destinations with the same most significant bit, at most one of them is accepted per cycle.
- R5: While both inputs of an element keep requesting the same exit, and that exit can take a packet every cycle, the grant alternates between the two inputs.
- R6: While an output is valid and its `outReady` is 0, the output stays valid and its payload stays unchanged, and no packet is lost.
- R7: When the destination is the source index XOR a constant, the permutation has no conflicts. All N packets are accepted on the same edge and all N leave on the same later edge.
- R8: Packets that share a source and a destination leave in the order they were accepted.
- R9: While a destination is blocked and its path is full, a packet from another source whose path needs one of those full registers sees `inReady` held at 0. A packet on a disjoint path is still delivered.
- R10: After injection stops and every output is ready, the network empties: all `outValid` bits fall to 0 and the count of delivered packets equals the count of accepted packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | NPORT | Per-input packet valid |
| inDest | input | NPORT*LOG2N | Per-input destination port; input s uses bits [s*LOG2N +: LOG2N] |
| inPayload | input | NPORT*PAY_W | Per-input payload; input s uses bits [s*PAY_W +: PAY_W] |
| inReady | output | NPORT | Per-input accept; a packet transfers on an edge where valid and ready are both high |
| outValid | output | NPORT | Per-output packet valid |
| outPayload | output | NPORT*PAY_W | Per-output payload; output p uses bits [p*PAY_W +: PAY_W] |
| outReady | input | NPORT | Per-output sink ready |

## Verification
A wrong steering bit or a wrong shuffle rotation sends a packet to the wrong port. The bench sees this on the edge that delivers the packet, because each payload carries the destination it was sent to. A lost or duplicated register load breaks the per-pair sequence numbers at the next delivery on that pair. It also shows as a count mismatch once the network drains. A round-robin pointer that does not toggle produces two consecutive deliveries from the same source in the contention test. A full flag that clears while its output is stalled drops the held packet within the blocked-output window.

// File: rtl/cube_route_pkg.sv
package cube_route_pkg;

  // Strobes from an element's control to its datapath, indexed by exit
  // (0 = upper, 1 = lower).
  typedef struct packed {
    logic [1:0] load;  // capture a new word into the exit register
    logic [1:0] pick;  // which element input feeds that exit
  } elemStrobe_t;

endpackage

// File: rtl/cube_route_ctrl.sv
module cube_route_ctrl
  import cube_route_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  inValid,
  input  logic [1:0]  steer,     // routing bit of each input word
  output logic [1:0]  inReady,
  output logic [1:0]  outValid,
  input  logic [1:0]  outReady,
  output elemStrobe_t strobe
);

  logic [1:0]      full;
  logic            prio;        // input favoured on the next clash
  logic [1:0][1:0] want;        // want[exit][input]
  logic [1:0]      canLoad;
  logic [1:0]      clash;
  logic [1:0]      pickSel;
  logic [1:0]      loadEn;

  always_comb begin
    for (int o = 0; o < 2; o++) begin
      for (int i = 0; i < 2; i++) begin
        want[o][i] = inValid[i] && (steer[i] == o[0]);
      end
      canLoad[o] = !full[o] || outReady[o];
      clash[o]   = want[o][0] && want[o][1];
      pickSel[o] = clash[o] ? prio : want[o][1];
      loadEn[o]  = canLoad[o] && (want[o] != 2'b00);
    end
    for (int i = 0; i < 2; i++) begin
      inReady[i] = inValid[i] && loadEn[steer[i]] && (pickSel[steer[i]] == i[0]);
    end
  end

  assign strobe.load = loadEn;
  assign strobe.pick = pickSel;
  assign outValid    = full;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      full <= '0;
      prio <= 1'b0;
    end else begin
      for (int o = 0; o < 2; o++) begin
        if (loadEn[o])        full[o] <= 1'b1;
        else if (outReady[o]) full[o] <= 1'b0;
      end
      if ((clash[0] && canLoad[0]) || (clash[1] && canLoad[1])) prio <= ~prio;
    end
  end

  for (genvar o = 0; o < 2; o++) begin : g_exitChk
    // R6: a stalled exit register keeps its packet
    a_r6_hold_full: assert property (@(posedge clk) disable iff (!rstN)
      (full[o] && !outReady[o]) |=> full[o]);
    // R5: back-to-back resolved clashes go to different inputs
    a_r5_alternate: assert property (@(posedge clk) disable iff (!rstN)
      (clash[o] && canLoad[o]) |=>
        (!(clash[o] && canLoad[o]) || (pickSel[o] != $past(pickSel[o]))));
  end

  for (genvar i = 0; i < 2; i++) begin : g_inChk
    // R4: an accepted packet lands in the exit named by its routing bit
    a_r4_accept_lands: assert property (@(posedge clk) disable iff (!rstN)
      (inValid[i] && inReady[i]) |=> full[$past(steer[i])]);
  end

endmodule

// File: rtl/cube_route_data.sv
module cube_route_data
  import cube_route_pkg::*;
#(
  parameter int WORD_W = 20
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [1:0][WORD_W-1:0] inWord,
  input  elemStrobe_t            strobe,
  output logic [1:0][WORD_W-1:0] outWord
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outWord <= '0;
    end else begin
      for (int o = 0; o < 2; o++) begin
        if (strobe.load[o]) outWord[o] <= inWord[strobe.pick[o]];
      end
    end
  end

endmodule

// File: rtl/cube_route_elem.sv
module cube_route_elem
  import cube_route_pkg::*;
#(
  parameter int WORD_W    = 20,
  parameter int STEER_BIT = 19
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [1:0]             inValid,
  input  logic [1:0][WORD_W-1:0] inWord,
  output logic [1:0]             inReady,
  output logic [1:0]             outValid,
  output logic [1:0][WORD_W-1:0] outWord,
  input  logic [1:0]             outReady
);

  elemStrobe_t strobe;
  logic [1:0]  steer;

  assign steer = {inWord[1][STEER_BIT], inWord[0][STEER_BIT]};

  cube_route_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .steer    (steer),
    .inReady  (inReady),
    .outValid (outValid),
    .outReady (outReady),
    .strobe   (strobe)
  );

  cube_route_data #(.WORD_W(WORD_W)) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .inWord  (inWord),
    .strobe  (strobe),
    .outWord (outWord)
  );

endmodule

// File: rtl/cube_route_net.sv
module cube_route_net #(
  parameter int LOG2N = 4,
  parameter int PAY_W = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [(1<<LOG2N)-1:0]       inValid,
  input  logic [(1<<LOG2N)*LOG2N-1:0] inDest,
  input  logic [(1<<LOG2N)*PAY_W-1:0] inPayload,
  output logic [(1<<LOG2N)-1:0]       inReady,
  output logic [(1<<LOG2N)-1:0]       outValid,
  output logic [(1<<LOG2N)*PAY_W-1:0] outPayload,
  input  logic [(1<<LOG2N)-1:0]       outReady
);

  localparam int NPORT  = 1 << LOG2N;
  localparam int NELEM  = NPORT / 2;
  localparam int WORD_W = LOG2N + PAY_W;

  // line level k feeds stage k; level LOG2N is the network output
  logic [LOG2N:0][NPORT-1:0]             lineValid;
  logic [LOG2N:0][NPORT-1:0]             lineReady;
  logic [LOG2N:0][NPORT-1:0][WORD_W-1:0] lineWord;

  for (genvar s = 0; s < NPORT; s++) begin : g_edge
    assign lineValid[0][s] = inValid[s];
    assign lineWord[0][s]  = {inDest[s*LOG2N +: LOG2N], inPayload[s*PAY_W +: PAY_W]};
    assign inReady[s]      = lineReady[0][s];
    assign outValid[s]                 = lineValid[LOG2N][s];
    assign outPayload[s*PAY_W +: PAY_W] = lineWord[LOG2N][s][PAY_W-1:0];
    assign lineReady[LOG2N][s]         = outReady[s];
  end

  for (genvar k = 0; k < LOG2N; k++) begin : g_stage
    for (genvar j = 0; j < NELEM; j++) begin : g_elem
      // element position p takes line q where rotate-left(q) == p
      localparam int P0 = 2 * j;
      localparam int P1 = 2 * j + 1;
      localparam int Q0 = (P0 >> 1) | ((P0 & 1) << (LOG2N - 1));
      localparam int Q1 = (P1 >> 1) | ((P1 & 1) << (LOG2N - 1));

      logic [1:0]             eInReady;
      logic [1:0]             eOutValid;
      logic [1:0][WORD_W-1:0] eOutWord;

      cube_route_elem #(
        .WORD_W    (WORD_W),
        .STEER_BIT (PAY_W + LOG2N - 1 - k)
      ) u_elem (
        .clk      (clk),
        .rstN     (rstN),
        .inValid  ({lineValid[k][Q1], lineValid[k][Q0]}),
        .inWord   ({lineWord[k][Q1], lineWord[k][Q0]}),
        .inReady  (eInReady),
        .outValid (eOutValid),
        .outWord  (eOutWord),
        .outReady ({lineReady[k+1][P1], lineReady[k+1][P0]})
      );

      assign lineReady[k][Q0]   = eInReady[0];
      assign lineReady[k][Q1]   = eInReady[1];
      assign lineValid[k+1][P0] = eOutValid[0];
      assign lineValid[k+1][P1] = eOutValid[1];
      assign lineWord[k+1][P0]  = eOutWord[0];
      assign lineWord[k+1][P1]  = eOutWord[1];
    end
  end

  // R1: nothing is presented on the edge that ends reset
  a_r1_reset_empty: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (outValid == '0));

  for (genvar p = 0; p < NPORT; p++) begin : g_outChk
    // R2: a word reaching port p was addressed to p
    a_r2_port_matches_dest: assert property (@(posedge clk) disable iff (!rstN)
      outValid[p] |-> (lineWord[LOG2N][p][PAY_W +: LOG2N] == LOG2N'(p)));
    // R6: stalled output keeps its payload
    a_r6_out_hold: assert property (@(posedge clk) disable iff (!rstN)
      (outValid[p] && !outReady[p]) |=>
        (outValid[p] && $stable(outPayload[p*PAY_W +: PAY_W])));
  end

endmodule

// File: tb/sim_cube_route_net.sv
`timescale 1ns/1ps
module sim_cube_route_net;

  localparam int LOG2N = 4;
  localparam int NP    = 16;
  localparam int PW    = 16;
  localparam int QD    = 64;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [NP-1:0]    inValid = '0;
  logic [NP*4-1:0]  inDest = '0;
  logic [NP*PW-1:0] inPayload = '0;
  logic [NP-1:0]    inReady;
  logic [NP-1:0]    outValid;
  logic [NP*PW-1:0] outPayload;
  logic [NP-1:0]    sinkMask = '1;

  always #4 clk = ~clk;  // 125 MHz

  cube_route_net #(.LOG2N(LOG2N), .PAY_W(PW)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inDest(inDest),
    .inPayload(inPayload), .inReady(inReady), .outValid(outValid),
    .outPayload(outPayload), .outReady(sinkMask)
  );

  int checks = 0, fails = 0;
  int cyc = 0, lastAccCyc = 0, expLat = 4;
  int pushed = 0, received = 0;
  int maxAccPop = 0, maxDelPop = 0;
  bit latencyMode = 0, randomSink = 0;
  logic [15:0] lfsrS = 16'hACE1, lfsrD = 16'h1D2B;
  logic [3:0]  qDest [NP][QD];
  logic [PW-1:0] qPay [NP][QD];
  int qHead [NP], qTail [NP];
  int seqNext [NP][NP], expSeq [NP][NP];
  int logPort = -1, logN = 0;
  int logSrc [32];
  logic [NP-1:0]    accMask = '0, delMask = '0;
  logic [NP*PW-1:0] delPay = '0;
  int sM, dM, qM;

  // {src, dst, expected latency}
  localparam logic [11:0] VEC [12] = '{
    {4'd0, 4'd0, 4'd4},  {4'd0, 4'd15, 4'd4}, {4'd15, 4'd0, 4'd4},
    {4'd5, 4'd10, 4'd4}, {4'd10, 4'd5, 4'd4}, {4'd3, 4'd3, 4'd4},
    {4'd7, 4'd8, 4'd4},  {4'd8, 4'd7, 4'd4},  {4'd12, 4'd1, 4'd4},
    {4'd1, 4'd12, 4'd4}, {4'd9, 4'd6, 4'd4},  {4'd14, 4'd9, 4'd4}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pushPkt(input int s, input int d);
    qDest[s][qTail[s]] = 4'(d);
    qPay[s][qTail[s]]  = {4'(s), 4'(d), 8'(seqNext[s][d])};
    seqNext[s][d]++;
    qTail[s]++;
    pushed++;
  endtask

  task automatic waitDrain(input int limit, output bit ok);
    ok = 0;
    for (int i = 0; i < limit; i++) begin
      @(posedge clk); #1;
      if (received == pushed && outValid == '0) begin ok = 1; break; end
    end
  endtask

  // edge capture of both handshakes
  always @(posedge clk) begin
    cyc     <= cyc + 1;
    accMask <= inValid & inReady;
    delMask <= outValid & sinkMask;
    delPay  <= outPayload;
  end

  // source driver
  always @(negedge clk) begin
    if (accMask != '0) lastAccCyc = cyc;
    if ($countones(accMask) > maxAccPop) maxAccPop = $countones(accMask);
    for (int s = 0; s < NP; s++) begin
      if (accMask[s]) qHead[s]++;
      if (qHead[s] < qTail[s]) begin
        inValid[s]            = 1'b1;
        inDest[s*4 +: 4]      = qDest[s][qHead[s]];
        inPayload[s*PW +: PW] = qPay[s][qHead[s]];
      end else begin
        inValid[s] = 1'b0;
      end
    end
    if (randomSink) begin
      lfsrS    = {lfsrS[14:0], lfsrS[15] ^ lfsrS[13] ^ lfsrS[12] ^ lfsrS[10]};
      sinkMask = lfsrS;
    end
  end

  // delivery monitor
  always @(negedge clk) begin
    if ($countones(delMask) > maxDelPop) maxDelPop = $countones(delMask);
    for (int p = 0; p < NP; p++) begin
      if (delMask[p]) begin
        sM = int'(delPay[p*PW+12 +: 4]);
        dM = int'(delPay[p*PW+8 +: 4]);
        qM = int'(delPay[p*PW +: 8]);
        chk(dM == p, "R2 delivered on port of its destination", p, dM);
        chk(qM == expSeq[sM][dM], "R8 per-pair order and exactly-once", qM, expSeq[sM][dM]);
        expSeq[sM][dM] = qM + 1;
        received++;
        if (latencyMode)
          chk(cyc - lastAccCyc == expLat, "R3 latency in edges", cyc - lastAccCyc, expLat);
        if (p == logPort && logN < 32) begin logSrc[logN] = sM; logN++; end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R10 network did not finish actual=%0d expected=%0d", cyc, 20000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    bit ok;
    logic [PW-1:0] firstPay, heldPay;
    int rcv0, r0;
    for (int s = 0; s < NP; s++) begin
      qHead[s] = 0; qTail[s] = 0;
      for (int d = 0; d < NP; d++) begin seqNext[s][d] = 0; expSeq[s][d] = 0; end
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    chk(outValid == '0, "R1 outputs empty after reset", int'(outValid), 0);
    chk(inReady == '0, "R1 no ready without valid", int'(inReady), 0);

    // table walk: single packets, latency and port
    latencyMode = 1;
    for (int v = 0; v < 12; v++) begin
      r0 = received;
      expLat = int'(VEC[v][3:0]);
      pushPkt(int'(VEC[v][11:8]), int'(VEC[v][7:4]));
      waitDrain(40, ok);
      chk(ok && received == r0 + 1, "R2 single packet delivered once", received - r0, 1);
    end
    latencyMode = 0;

    // R7 conflict-free XOR permutations
    for (int c = 0; c < 2; c++) begin
      maxAccPop = 0; maxDelPop = 0;
      for (int s = 0; s < NP; s++) pushPkt(s, s ^ (c == 0 ? 15 : 5));
      waitDrain(40, ok);
      chk(maxAccPop == NP, "R7 all accepted on one edge", maxAccPop, NP);
      chk(maxDelPop == NP, "R7 all delivered on one edge", maxDelPop, NP);
    end

    // R4/R5 contention: inputs 0 and 8 to destination 3
    maxAccPop = 0; logPort = 3; logN = 0;
    for (int n = 0; n < 6; n++) begin pushPkt(0, 3); pushPkt(8, 3); end
    waitDrain(80, ok);
    chk(maxAccPop == 1, "R4 one of two contenders accepted per cycle", maxAccPop, 1);
    chk(logN == 12, "R5 contention deliveries", logN, 12);
    r0 = 0;
    for (int k = 1; k < 12; k++) if (logSrc[k] == logSrc[k-1]) r0++;
    chk(r0 == 0, "R5 grants alternate", r0, 0);
    logPort = -1;

    // R6 blocked output holds
    sinkMask[5] = 1'b0;
    firstPay = {4'd2, 4'd5, 8'(seqNext[2][5])};
    rcv0 = received;
    for (int n = 0; n < 3; n++) pushPkt(2, 5);
    repeat (12) @(posedge clk); #1;
    chk(outValid[5] == 1'b1, "R6 blocked output stays valid", int'(outValid[5]), 1);
    chk(outPayload[5*PW +: PW] == firstPay, "R6 held payload", int'(outPayload[5*PW +: PW]), int'(firstPay));
    heldPay = outPayload[5*PW +: PW];
    repeat (5) @(posedge clk); #1;
    chk(outPayload[5*PW +: PW] == heldPay && received == rcv0, "R6 payload stable, none lost",
        received - rcv0, 0);

    // R9 tree saturation
    for (int n = 0; n < 3; n++) pushPkt(2, 5);
    pushPkt(10, 4);
    pushPkt(1, 12);
    repeat (12) @(posedge clk); #1;
    chk(inValid[10] && !inReady[10], "R9 sharer stalled", int'(inReady[10]), 0);
    chk(expSeq[10][4] != seqNext[10][4], "R9 sharer not delivered", expSeq[10][4], seqNext[10][4] - 1);
    chk(expSeq[1][12] == seqNext[1][12], "R9 disjoint path delivered", expSeq[1][12], seqNext[1][12]);
    sinkMask[5] = 1'b1;
    waitDrain(80, ok);
    chk(ok, "R6 blocked packets drain after release", int'(ok), 1);

    // mixed traffic with random sinks
    for (int r = 0; r < 10; r++) begin
      for (int s = 0; s < NP; s++) begin
        lfsrD = {lfsrD[14:0], lfsrD[15] ^ lfsrD[13] ^ lfsrD[12] ^ lfsrD[10]};
        pushPkt(s, int'(lfsrD[3:0]));
      end
    end
    randomSink = 1;
    repeat (300) @(posedge clk);
    randomSink = 0;
    #1 sinkMask = '1;

    // R10 drain
    waitDrain(600, ok);
    chk(ok, "R10 network drains", received, pushed);
    chk(outValid == '0, "R10 all outputs empty", int'(outValid), 0);
    chk(received == pushed, "R10 delivered equals accepted", received, pushed);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule